// File: doc/BRIEF.md
# Instruction Field Decoder and Operand Address Generator

This block splits a fetched 32-bit instruction word into its operation code and register fields. It turns each register field into a one-hot select line and sign-extends the constant field. For the three memory-class operations it also forms the operand: the effective address for load and store, and the immediate value for load-immediate. The Rb field names the base register. When that field is zero, the base contribution is zero whatever register 0 holds, so the constant alone becomes the address or value. Any other base register adds its read value to the constant. One field layout therefore covers direct, indexed, register-indirect (constant zero) and immediate modes.

Control sequencing sits outside the block. The block presents the raw 5-bit operation code and a 2-bit access class. A 9-bit word address for a 512-word memory is taken from the low bits of the effective address. By default all outputs are registered, one cycle after the instruction and base value are presented.

Top module: `instr_field_decoder`

## Requirements
- R1: The `opcode_o` output shows instruction bits 31..27 one clock after the instruction is presented.
- R2: `sel_a_o`, `sel_b_o` and `sel_c_o` are 16-bit one-hot decodes of bits 26..23, 22..19 and 18..15 respectively (bit n set for register n). Each output is all zero when its own enable was low.
- R3: `const_o` is bits 18..0 sign-extended to 32 bits, with bit 18 copied into bits 31..19.
- R4: `base_zero_o` is 1 exactly when bits 22..19 are 0000.
- R5: For operation code 00000 (load, class 01) and 00010 (store, class 11), `operand_o` is the sign-extended constant when the base field is 0000. Otherwise it is `base_val_i` plus the constant, modulo 2^32, so a zero constant gives the register value unchanged.
- R6: For operation code 00001 (load-immediate, class 10), `operand_o` follows the same rule as R5.
- R7: Any other operation code gives access class 00, and both `operand_o` and `mem_addr_o` are zero.
- R8: For load and store, `mem_addr_o` equals bits 8..0 of `operand_o`. For every other class it is zero.
- R9: An active-low reset clears every output to zero.
- R10: When the base field is 0000, the value on `base_val_i` has no effect on `operand_o` or `mem_addr_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_i | input | 32 | Instruction word |
| base_val_i | input | 32 | Register file read value for the Rb field |
| sel_a_en_i | input | 1 | Enable for the Ra select decode |
| sel_b_en_i | input | 1 | Enable for the Rb select decode |
| sel_c_en_i | input | 1 | Enable for the Rc select decode |
| opcode_o | output | 5 | Raw operation code |
| sel_a_o | output | 16 | One-hot Ra select |
| sel_b_o | output | 16 | One-hot Rb select |
| sel_c_o | output | 16 | One-hot Rc select |
| const_o | output | 32 | Sign-extended constant |
| base_zero_o | output | 1 | Base field names register 0 |
| kind_o | output | 2 | Access class: 00 other, 01 load, 10 load-immediate, 11 store |
| operand_o | output | 32 | Effective address or immediate value |
| mem_addr_o | output | 9 | Word address for memory |

## Verification
The bench builds the block with its default parameters: a 32-bit word, 4-bit register fields, 512 memory words and the registered output stage. This is the layout every requirement is written against. The registered variant makes the one-cycle latency and the reset clearing observable. The 19-bit constant together with a full-range base value allows sign-extension of negative constants, wrap-around of the 32-bit sum, and truncation to a 9-bit word address to be tested. Random base values driven while the base field is zero expose any leak of register 0 into the operand.

// File: rtl/ifd_pkg.sv
package ifd_pkg;
   typedef enum logic [1:0] {
      ACC_NONE  = 2'b00,
      ACC_LOAD  = 2'b01,
      ACC_LDIMM = 2'b10,
      ACC_STORE = 2'b11
   } acc_kind_t;
endpackage

// File: rtl/ifd_field_split.sv
module ifd_field_split #(
   parameter int DATA_W = 32,
   parameter int OPC_W  = 5,
   parameter int REG_W  = 4
) (
   input  logic [DATA_W-1:0] instr,
   output logic [OPC_W-1:0]  opc,
   output logic [REG_W-1:0]  fa,
   output logic [REG_W-1:0]  fb,
   output logic [REG_W-1:0]  fc,
   output logic [DATA_W-1:0] cext
);
   localparam int OPC_LSB = DATA_W - OPC_W;
   localparam int FA_LSB  = OPC_LSB - REG_W;
   localparam int FB_LSB  = FA_LSB - REG_W;
   localparam int FC_LSB  = FB_LSB - REG_W;
   localparam int CONST_W = FB_LSB;

   assign opc  = instr[DATA_W-1 -: OPC_W];
   assign fa   = instr[FA_LSB +: REG_W];
   assign fb   = instr[FB_LSB +: REG_W];
   assign fc   = instr[FC_LSB +: REG_W];
   assign cext = {{(DATA_W-CONST_W){instr[CONST_W-1]}}, instr[CONST_W-1:0]};
endmodule

// File: rtl/ifd_onehot_sel.sv
module ifd_onehot_sel #(
   parameter int REG_W = 4
) (
   input  logic                  en,
   input  logic [REG_W-1:0]      idx,
   output logic [(1<<REG_W)-1:0] sel
);
   localparam int NREG = 1 << REG_W;

   for (genvar i = 0; i < NREG; i++) begin : g_line
      assign sel[i] = en && (idx == REG_W'(i));
   end
endmodule

// File: rtl/ifd_addr_gen.sv
module ifd_addr_gen
   import ifd_pkg::*;
#(
   parameter int             DATA_W    = 32,
   parameter int             OPC_W     = 5,
   parameter int             REG_W     = 4,
   parameter int             ADDR_W    = 9,
   parameter logic [OPC_W-1:0] OPC_LOAD  = 5'b00000,
   parameter logic [OPC_W-1:0] OPC_LDIMM = 5'b00001,
   parameter logic [OPC_W-1:0] OPC_STORE = 5'b00010
) (
   input  logic [OPC_W-1:0]  opc,
   input  logic [REG_W-1:0]  fb,
   input  logic [DATA_W-1:0] cext,
   input  logic [DATA_W-1:0] base_val,
   output acc_kind_t         kind,
   output logic              base_zero,
   output logic [DATA_W-1:0] operand,
   output logic [ADDR_W-1:0] mem_addr
);
   logic [DATA_W-1:0] base_eff;
   logic [DATA_W-1:0] sum;

   assign base_zero = (fb == '0);
   assign base_eff  = base_zero ? '0 : base_val;
   assign sum       = base_eff + cext;

   always_comb begin
      case (opc)
         OPC_LOAD:  kind = ACC_LOAD;
         OPC_LDIMM: kind = ACC_LDIMM;
         OPC_STORE: kind = ACC_STORE;
         default:   kind = ACC_NONE;
      endcase
   end

   assign operand  = (kind == ACC_NONE) ? '0 : sum;
   assign mem_addr = (kind == ACC_LOAD || kind == ACC_STORE) ? sum[ADDR_W-1:0] : '0;
endmodule

// File: rtl/instr_field_decoder.sv
module instr_field_decoder
   import ifd_pkg::*;
#(
   parameter int DATA_W    = 32,
   parameter int OPC_W     = 5,
   parameter int REG_W     = 4,
   parameter int MEM_WORDS = 512,
   parameter bit REG_OUT   = 1'b1,
   parameter logic [OPC_W-1:0] OPC_LOAD  = 5'b00000,
   parameter logic [OPC_W-1:0] OPC_LDIMM = 5'b00001,
   parameter logic [OPC_W-1:0] OPC_STORE = 5'b00010,
   localparam int NREG   = 1 << REG_W,
   localparam int ADDR_W = $clog2(MEM_WORDS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] instr_i,
   input  logic [DATA_W-1:0] base_val_i,
   input  logic              sel_a_en_i,
   input  logic              sel_b_en_i,
   input  logic              sel_c_en_i,
   output logic [OPC_W-1:0]  opcode_o,
   output logic [NREG-1:0]   sel_a_o,
   output logic [NREG-1:0]   sel_b_o,
   output logic [NREG-1:0]   sel_c_o,
   output logic [DATA_W-1:0] const_o,
   output logic              base_zero_o,
   output logic [1:0]        kind_o,
   output logic [DATA_W-1:0] operand_o,
   output logic [ADDR_W-1:0] mem_addr_o
);
   if (DATA_W <= OPC_W + 3*REG_W) begin : g_bad_layout
      $error("instr_field_decoder: word too narrow for the field layout");
   end
   if (ADDR_W >= DATA_W) begin : g_bad_addr
      $error("instr_field_decoder: memory address must be narrower than the word");
   end
   if ((1 << ADDR_W) != MEM_WORDS) begin : g_bad_depth
      $error("instr_field_decoder: memory depth must be a power of two");
   end

   logic [OPC_W-1:0]  opc_c;
   logic [REG_W-1:0]  fa_c, fb_c, fc_c;
   logic [DATA_W-1:0] cext_c;
   logic [NREG-1:0]   sa_c, sb_c, sc_c;
   acc_kind_t         kind_c;
   logic              bz_c;
   logic [DATA_W-1:0] opnd_c;
   logic [ADDR_W-1:0] maddr_c;

   ifd_field_split #(.DATA_W(DATA_W), .OPC_W(OPC_W), .REG_W(REG_W)) u_split (
      .instr (instr_i),
      .opc   (opc_c),
      .fa    (fa_c),
      .fb    (fb_c),
      .fc    (fc_c),
      .cext  (cext_c)
   );

   ifd_onehot_sel #(.REG_W(REG_W)) u_sel_a (.en(sel_a_en_i), .idx(fa_c), .sel(sa_c));
   ifd_onehot_sel #(.REG_W(REG_W)) u_sel_b (.en(sel_b_en_i), .idx(fb_c), .sel(sb_c));
   ifd_onehot_sel #(.REG_W(REG_W)) u_sel_c (.en(sel_c_en_i), .idx(fc_c), .sel(sc_c));

   ifd_addr_gen #(
      .DATA_W(DATA_W), .OPC_W(OPC_W), .REG_W(REG_W), .ADDR_W(ADDR_W),
      .OPC_LOAD(OPC_LOAD), .OPC_LDIMM(OPC_LDIMM), .OPC_STORE(OPC_STORE)
   ) u_addr (
      .opc       (opc_c),
      .fb        (fb_c),
      .cext      (cext_c),
      .base_val  (base_val_i),
      .kind      (kind_c),
      .base_zero (bz_c),
      .operand   (opnd_c),
      .mem_addr  (maddr_c)
   );

   if (REG_OUT) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            opcode_o    <= '0;
            sel_a_o     <= '0;
            sel_b_o     <= '0;
            sel_c_o     <= '0;
            const_o     <= '0;
            base_zero_o <= 1'b0;
            kind_o      <= ACC_NONE;
            operand_o   <= '0;
            mem_addr_o  <= '0;
         end else begin
            opcode_o    <= opc_c;
            sel_a_o     <= sa_c;
            sel_b_o     <= sb_c;
            sel_c_o     <= sc_c;
            const_o     <= cext_c;
            base_zero_o <= bz_c;
            kind_o      <= kind_c;
            operand_o   <= opnd_c;
            mem_addr_o  <= maddr_c;
         end
      end
   end else begin : g_comb
      assign opcode_o    = opc_c;
      assign sel_a_o     = sa_c;
      assign sel_b_o     = sb_c;
      assign sel_c_o     = sc_c;
      assign const_o     = cext_c;
      assign base_zero_o = bz_c;
      assign kind_o      = kind_c;
      assign operand_o   = opnd_c;
      assign mem_addr_o  = maddr_c;
   end
endmodule

// File: rtl/ifd_checker.sv
module ifd_checker #(
   parameter int DATA_W    = 32,
   parameter int OPC_W     = 5,
   parameter int REG_W     = 4,
   parameter int MEM_WORDS = 512,
   parameter bit REG_OUT   = 1'b1,
   localparam int NREG   = 1 << REG_W,
   localparam int ADDR_W = $clog2(MEM_WORDS),
   localparam int FB_LSB = DATA_W - OPC_W - 2*REG_W
) (
   input logic              clk,
   input logic              rst_n,
   input logic [DATA_W-1:0] instr_i,
   input logic              sel_a_en_i,
   input logic              sel_b_en_i,
   input logic              sel_c_en_i,
   input logic [OPC_W-1:0]  opcode_o,
   input logic [NREG-1:0]   sel_a_o,
   input logic [NREG-1:0]   sel_b_o,
   input logic [NREG-1:0]   sel_c_o,
   input logic [DATA_W-1:0] const_o,
   input logic              base_zero_o,
   input logic [1:0]        kind_o,
   input logic [DATA_W-1:0] operand_o,
   input logic [ADDR_W-1:0] mem_addr_o
);
   logic primed;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) primed <= 1'b0;
      else        primed <= 1'b1;
   end

   assert_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(sel_a_o) && $onehot0(sel_b_o) && $onehot0(sel_c_o));

   assert_none_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (kind_o == 2'b00) |-> (operand_o == '0 && mem_addr_o == '0));

   assert_addr_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (kind_o == 2'b01 || kind_o == 2'b11) |-> (mem_addr_o == operand_o[ADDR_W-1:0]));

   assert_direct_const_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (base_zero_o && kind_o != 2'b00) |-> (operand_o == const_o));

   if (REG_OUT) begin : g_timed
      assert_opcode_delay_R1: assert property (@(posedge clk) disable iff (!rst_n || !primed)
         opcode_o == $past(instr_i[DATA_W-1 -: OPC_W]));

      assert_sel_gate_R2: assert property (@(posedge clk) disable iff (!rst_n || !primed)
         (!$past(sel_a_en_i) |-> sel_a_o == '0) and
         (!$past(sel_b_en_i) |-> sel_b_o == '0) and
         (!$past(sel_c_en_i) |-> sel_c_o == '0));

      assert_base_zero_R4: assert property (@(posedge clk) disable iff (!rst_n || !primed)
         base_zero_o == ($past(instr_i[FB_LSB +: REG_W]) == '0));

      assert_reset_clear_R9: assert property (@(posedge clk)
         !rst_n |=> (opcode_o == '0 && kind_o == '0 && operand_o == '0 &&
                     sel_a_o == '0 && const_o == '0 && !base_zero_o));
   end
endmodule

bind instr_field_decoder ifd_checker #(
   .DATA_W(DATA_W), .OPC_W(OPC_W), .REG_W(REG_W),
   .MEM_WORDS(MEM_WORDS), .REG_OUT(REG_OUT)
) u_ifd_checker (
   .clk(clk), .rst_n(rst_n), .instr_i(instr_i),
   .sel_a_en_i(sel_a_en_i), .sel_b_en_i(sel_b_en_i), .sel_c_en_i(sel_c_en_i),
   .opcode_o(opcode_o), .sel_a_o(sel_a_o), .sel_b_o(sel_b_o), .sel_c_o(sel_c_o),
   .const_o(const_o), .base_zero_o(base_zero_o), .kind_o(kind_o),
   .operand_o(operand_o), .mem_addr_o(mem_addr_o)
);

// File: tb/instr_field_decoder_test.sv
module instr_field_decoder_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] instr_i = '0;
   logic [31:0] base_val_i = '0;
   logic        sel_a_en_i = 1'b0, sel_b_en_i = 1'b0, sel_c_en_i = 1'b0;
   logic [4:0]  opcode_o;
   logic [15:0] sel_a_o, sel_b_o, sel_c_o;
   logic [31:0] const_o;
   logic        base_zero_o;
   logic [1:0]  kind_o;
   logic [31:0] operand_o;
   logic [8:0]  mem_addr_o;

   int compared = 0;
   int mismatched = 0;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   instr_field_decoder uut (
      .clk(clk), .rst_n(rst_n), .instr_i(instr_i), .base_val_i(base_val_i),
      .sel_a_en_i(sel_a_en_i), .sel_b_en_i(sel_b_en_i), .sel_c_en_i(sel_c_en_i),
      .opcode_o(opcode_o), .sel_a_o(sel_a_o), .sel_b_o(sel_b_o), .sel_c_o(sel_c_o),
      .const_o(const_o), .base_zero_o(base_zero_o), .kind_o(kind_o),
      .operand_o(operand_o), .mem_addr_o(mem_addr_o)
   );

   function automatic logic [31:0] f_sext(input logic [31:0] w);
      return {{13{w[18]}}, w[18:0]};
   endfunction

   function automatic logic [1:0] f_kind(input logic [31:0] w);
      case (w[31:27])
         5'b00000: return 2'b01;
         5'b00001: return 2'b10;
         5'b00010: return 2'b11;
         default:  return 2'b00;
      endcase
   endfunction

   function automatic logic [31:0] f_operand(input logic [31:0] w, input logic [31:0] b);
      if (f_kind(w) == 2'b00) return 32'h0;
      if (w[22:19] == 4'h0)   return f_sext(w);
      return b + f_sext(w);
   endfunction

   function automatic logic [15:0] f_sel(input logic en, input logic [3:0] idx);
      return en ? (16'h1 << idx) : 16'h0;
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      compared++;
      if (act !== exp) begin
         mismatched++;
         $display("FAIL %s: actual %h expected %h (instr %h base %h)", req, act, exp, instr_i, base_val_i);
      end
   endtask

   // Drive at a falling edge, let one rising edge capture, check at the next falling edge.
   task automatic apply(input logic [31:0] w, input logic [31:0] b, input logic [2:0] en);
      logic [1:0] k;
      instr_i = w; base_val_i = b;
      {sel_a_en_i, sel_b_en_i, sel_c_en_i} = en;
      @(posedge clk);
      @(negedge clk);
      k = f_kind(w);
      chk("R1 opcode", 32'(opcode_o), 32'(w[31:27]));
      chk("R2 sel_a", 32'(sel_a_o), 32'(f_sel(en[2], w[26:23])));
      chk("R2 sel_b", 32'(sel_b_o), 32'(f_sel(en[1], w[22:19])));
      chk("R2 sel_c", 32'(sel_c_o), 32'(f_sel(en[0], w[18:15])));
      chk("R3 const", const_o, f_sext(w));
      chk("R4 base_zero", 32'(base_zero_o), 32'(w[22:19] == 4'h0));
      chk("R7 kind", 32'(kind_o), 32'(k));
      chk(k == 2'b10 ? "R6 ldimm operand" : (k == 2'b00 ? "R7 operand" : "R5 operand"),
          operand_o, f_operand(w, b));
      chk("R8 mem_addr", 32'(mem_addr_o),
          (k == 2'b01 || k == 2'b11) ? 32'(f_operand(w, b) & 32'h1FF) : 32'h0);
   endtask

   function automatic logic [31:0] mk(input logic [4:0] op, input logic [3:0] ra,
                                      input logic [3:0] rb, input logic [18:0] c);
      return {op, ra, rb, c};
   endfunction

   task automatic reset_check();
      chk("R9 reset opcode", 32'(opcode_o), 32'h0);
      chk("R9 reset operand", operand_o, 32'h0);
      chk("R9 reset sel", 32'(sel_a_o | sel_b_o | sel_c_o), 32'h0);
      chk("R9 reset kind/bz/addr", {kind_o, base_zero_o, mem_addr_o}, 32'h0);
      chk("R9 reset const", const_o, 32'h0);
   endtask

   initial begin
      #(2_000_000);
      if (!finished) begin
         mismatched++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd2024));
      instr_i = mk(5'b00001, 4'd3, 4'd5, 19'h12345); base_val_i = 32'hFFFF_FFFF;
      repeat (3) @(posedge clk);
      @(negedge clk);
      reset_check();
      rst_n = 1'b1;

      // R5 direct load, base value must be ignored (R10)
      apply(mk(5'b00000, 4'd1, 4'd0, 19'h00123), 32'hDEAD_BEEF, 3'b111);
      // R10: same instruction, different base value, same result
      apply(mk(5'b00000, 4'd1, 4'd0, 19'h00123), 32'h0000_0777, 3'b111);
      // R5 indexed store with negative constant
      apply(mk(5'b00010, 4'd15, 4'd14, 19'h7FFFC), 32'h0000_0100, 3'b110);
      // R5 register indirect: constant zero
      apply(mk(5'b00000, 4'd2, 4'd9, 19'h0), 32'h1234_5AB7, 3'b101);
      // R5 wrap-around of the 32-bit sum
      apply(mk(5'b00010, 4'd0, 4'd7, 19'h00010), 32'hFFFF_FFF8, 3'b011);
      // R6 load-immediate direct with negative constant, base ignored (R10)
      apply(mk(5'b00001, 4'd4, 4'd0, 19'h40000), 32'h5555_5555, 3'b000);
      // R6 increment form
      apply(mk(5'b00001, 4'd6, 4'd6, 19'h00001), 32'h7FFF_FFFF, 3'b100);
      // R7 other opcodes
      apply(mk(5'b00011, 4'd8, 4'd3, 19'h1FFFF), 32'h0000_1000, 3'b111);
      apply(mk(5'b11111, 4'd15, 4'd15, 19'h7FFFF), 32'hFFFF_FFFF, 3'b111);
      // R2 all enables low
      apply(mk(5'b00000, 4'd12, 4'd13, 19'h7F000), 32'h0000_2000, 3'b000);

      for (int i = 0; i < 400; i++) begin
         logic [4:0]  op;
         logic [3:0]  rb;
         logic [31:0] w;
         op = ($urandom % 4 == 0) ? 5'($urandom) : 5'($urandom % 3);
         rb = ($urandom % 4 == 0) ? 4'h0 : 4'($urandom);
         w  = mk(op, 4'($urandom), rb, 19'($urandom));
         apply(w, $urandom, 3'($urandom));
      end

      // R9 mid-run reset
      @(negedge clk);
      rst_n = 1'b0;
      #1;
      reset_check();
      @(negedge clk);
      rst_n = 1'b1;
      apply(mk(5'b00010, 4'd5, 4'd0, 19'h001FF), 32'h0, 3'b111);

      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end
endmodule